// File: doc/BRIEF.md
# Partitioned FIR Multiply-Accumulate Engine

This block is a filter accelerator that computes finite-impulse-response outputs with a single signed 24 x 24 multiply-accumulate datapath. The datapath consumes one tap every clock. Sixty-four sample registers and sixty-four coefficient registers are shared between the channels. A static configuration input sets how they are used. In the first arrangement they form one filter with sixty-four taps. In the second they form four independent filters of sixteen taps each, and channel k owns entries 16k through 16k+15.

A producer, such as a DMA engine or a processor, pushes one sample at a time over a valid/ready port and tags it with a channel number. The sample is written over the oldest entry in that channel's history, and a filter pass starts at once. While the pass runs, the input port stays closed. When the pass ends, the rounded and saturated 24-bit result is held on a valid/ready output port until a consumer takes it. Coefficients are written one entry at a time through a separate write port.

Top module: `fir_mac_engine`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, and all sample and coefficient entries are zero. A sample pushed straight after reset therefore yields a result of 0.
- R2: The result is y = sum over i of c[base+i] * x[n-i], with i from 0 to N-1. Samples are signed two's complement integers. Coefficients are signed two's complement fractions with 23 fraction bits, so 0x400000 means 0.5.
- R3: With mode_split = 0 there is one channel of N = 64 taps using entries 0..63. in_chan is ignored, and out_chan is always 0.
- R4: With mode_split = 1, channel k = in_chan uses coefficient entries 16k+i and keeps its own 16-deep history. out_chan reports the channel of the sample that started the pass.
- R5: Each channel keeps a circular history of exactly N samples. A new sample replaces the oldest, so the sample pushed N pushes earlier no longer contributes.
- R6: out_valid rises exactly N+2 clock edges after the edge that accepts the sample: 66 edges in single mode and 18 edges in split mode.
- R7: in_ready is low from the accepting edge until the result has been taken. An in_valid raised during that time is not accepted and leaves the histories unchanged.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_chan hold. An edge with both high clears out_valid and reopens the input port.
- R9: The accumulated sum is scaled down by 2^23 with round-half-up, computed as (acc + 2^22) shifted arithmetically right by 23. So 1.5 gives 2 and -1.5 gives -1.
- R10: A scaled result outside the 24-bit signed range is clamped to 8388607 or -8388608.
- R11: A coefficient write with coef_we = 1 stores coef_wdata at entry coef_addr (0..63) on the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_split | input | 1 | 0: one 64-tap channel, 1: four 16-tap channels; changed only under reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 6 | Coefficient entry index |
| coef_wdata | input | 24 | Coefficient value, signed with 23 fraction bits |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Engine idle and able to take a sample |
| in_chan | input | 2 | Channel of the input sample (split mode only) |
| in_data | input | 24 | Signed input sample |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_chan | output | 2 | Channel the result belongs to |
| out_data | output | 24 | Rounded, saturated signed result |

## Verification
In single mode, a lone impulse followed by zeros plays the coefficient set back one entry per output. This exposes any error in tap ordering or coefficient addressing. A run of 66 distinct samples wraps the history, which separates a correct circular overwrite from an off-by-one depth. In split mode the four channels are interleaved over twenty rounds, so a mix-up between segments or a shared pointer gives wrong results on the other channels. A half-scale single tap fed plus and minus odd values separates round-half-up from truncation or symmetric rounding. Full-scale coefficients with extreme samples drive both saturation limits.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;
  localparam int unsigned DEF_SAMP_W  = 24;
  localparam int unsigned DEF_COEF_W  = 24;
  localparam int unsigned DEF_ENTRIES = 64;
  localparam int unsigned DEF_LANES   = 4;
  localparam int unsigned DEF_ACC_W   = 56;
  localparam int unsigned DEF_FRAC    = 23;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/fir_store.sv
module fir_store #(
  parameter int unsigned SAMP_W  = fir_mac_pkg::DEF_SAMP_W,
  parameter int unsigned COEF_W  = fir_mac_pkg::DEF_COEF_W,
  parameter int unsigned ENTRIES = fir_mac_pkg::DEF_ENTRIES,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_we,
  input  logic [IDX_W-1:0]  s_waddr,
  input  logic [SAMP_W-1:0] s_wdata,
  input  logic              c_we,
  input  logic [IDX_W-1:0]  c_waddr,
  input  logic [COEF_W-1:0] c_wdata,
  input  logic [IDX_W-1:0]  s_raddr,
  input  logic [IDX_W-1:0]  c_raddr,
  output logic [SAMP_W-1:0] s_rdata,
  output logic [COEF_W-1:0] c_rdata
);
  logic [SAMP_W-1:0] samp_arr [ENTRIES];
  logic [COEF_W-1:0] coef_arr [ENTRIES];

  // one register pair per storage entry, each with its own write enable
  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic              s_en, c_en;
    logic [SAMP_W-1:0] s_q;
    logic [COEF_W-1:0] c_q;

    assign s_en = s_we && (s_waddr == IDX_W'(g));
    assign c_en = c_we && (c_waddr == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_q <= '0;
        c_q <= '0;
      end else begin
        if (s_en) s_q <= s_wdata;
        if (c_en) c_q <= c_wdata;
      end
    end

    assign samp_arr[g] = s_q;
    assign coef_arr[g] = c_q;
  end

  assign s_rdata = samp_arr[s_raddr];
  assign c_rdata = coef_arr[c_raddr];
endmodule

// File: rtl/fir_seq.sv
module fir_seq #(
  parameter int unsigned ENTRIES  = fir_mac_pkg::DEF_ENTRIES,
  parameter int unsigned LANES    = fir_mac_pkg::DEF_LANES,
  localparam int unsigned IDX_W    = $clog2(ENTRIES),
  localparam int unsigned CH_W     = $clog2(LANES),
  localparam int unsigned LANE_LEN = ENTRIES / LANES,
  localparam int unsigned LANE_W   = $clog2(LANE_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_split,
  input  logic             in_valid,
  input  logic [CH_W-1:0]  in_chan,
  input  logic             pipe_busy,
  output logic             in_ready,
  output logic             s_we,
  output logic [IDX_W-1:0] s_waddr,
  output logic [IDX_W-1:0] s_raddr,
  output logic [IDX_W-1:0] c_raddr,
  output logic             tap_vld,
  output logic             tap_last,
  output logic             acc_clr,
  output logic [CH_W-1:0]  cur_chan
);
  import fir_mac_pkg::*;

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] tap_q, tap_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [CH_W-1:0]  ch_q, ch_d;
  logic [IDX_W-1:0] wptr_q [LANES];
  logic [IDX_W-1:0] wptr_d [LANES];

  logic [IDX_W-1:0] len_m1;
  logic [CH_W-1:0]  ch_eff;
  logic [IDX_W-1:0] base_in, base_cur, off;
  logic             fire;

  assign len_m1   = mode_split ? IDX_W'(LANE_LEN - 1) : IDX_W'(ENTRIES - 1);
  assign ch_eff   = mode_split ? in_chan : '0;
  assign base_in  = {ch_eff, {LANE_W{1'b0}}};
  assign base_cur = {ch_q,   {LANE_W{1'b0}}};

  assign in_ready = (state_q == SEQ_IDLE) && !pipe_busy;
  assign fire     = in_valid && in_ready;

  // write side: newest sample overwrites oldest slot of its segment
  assign s_we    = fire;
  assign s_waddr = base_in | wptr_q[ch_eff];

  // read side: tap i pairs coefficient i with the sample i pushes back
  assign off      = (ptr_q - tap_q) & len_m1;
  assign s_raddr  = base_cur | off;
  assign c_raddr  = base_cur | tap_q;
  assign tap_vld  = (state_q == SEQ_RUN);
  assign tap_last = tap_vld && (tap_q == len_m1);
  assign acc_clr  = fire;
  assign cur_chan = ch_q;

  always_comb begin
    state_d = state_q;
    tap_d   = tap_q;
    ptr_d   = ptr_q;
    ch_d    = ch_q;
    for (int k = 0; k < LANES; k++) wptr_d[k] = wptr_q[k];

    if (fire) begin
      state_d = SEQ_RUN;
      tap_d   = '0;
      ptr_d   = wptr_q[ch_eff];
      ch_d    = ch_eff;
      for (int k = 0; k < LANES; k++) begin
        if (CH_W'(k) == ch_eff) wptr_d[k] = (wptr_q[k] + 1'b1) & len_m1;
      end
    end else if (tap_vld) begin
      tap_d = tap_q + 1'b1;
      if (tap_last) state_d = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      tap_q   <= '0;
      ptr_q   <= '0;
      ch_q    <= '0;
      for (int k = 0; k < LANES; k++) wptr_q[k] <= '0;
    end else begin
      state_q <= state_d;
      tap_q   <= tap_d;
      ptr_q   <= ptr_d;
      ch_q    <= ch_d;
      for (int k = 0; k < LANES; k++) wptr_q[k] <= wptr_d[k];
    end
  end
endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
  parameter int unsigned SAMP_W = fir_mac_pkg::DEF_SAMP_W,
  parameter int unsigned COEF_W = fir_mac_pkg::DEF_COEF_W,
  parameter int unsigned ACC_W  = fir_mac_pkg::DEF_ACC_W,
  parameter int unsigned FRAC   = fir_mac_pkg::DEF_FRAC,
  parameter int unsigned CH_W   = 2,
  localparam int unsigned OUT_W = SAMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_clr,
  input  logic              tap_vld,
  input  logic              tap_last,
  input  logic [SAMP_W-1:0] s_rdata,
  input  logic [COEF_W-1:0] c_rdata,
  input  logic [CH_W-1:0]   chan_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data,
  output logic [CH_W-1:0]   out_chan,
  output logic              busy
);
  localparam logic signed [ACC_W-1:0] BIAS =
    {{(ACC_W-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] MAXV =
    {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MINV =
    {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  // stage 1: operand registers
  logic [SAMP_W-1:0] ops_q, ops_d;
  logic [COEF_W-1:0] opc_q, opc_d;
  logic              v1_q, v1_d, l1_q, l1_d;
  // stage 2: accumulator
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic              fin_q, fin_d;
  // output register
  logic              ov_q, ov_d;
  logic [OUT_W-1:0]  od_q, od_d;
  logic [CH_W-1:0]   oc_q, oc_d;

  logic signed [ACC_W-1:0] s_ext, c_ext, prod, rnd, scaled;
  logic [OUT_W-1:0]        clamped;

  assign s_ext  = ACC_W'($signed(ops_q));
  assign c_ext  = ACC_W'($signed(opc_q));
  assign prod   = s_ext * c_ext;
  assign rnd    = acc_q + BIAS;
  assign scaled = rnd >>> FRAC;

  always_comb begin
    if (scaled > MAXV)      clamped = MAXV[OUT_W-1:0];
    else if (scaled < MINV) clamped = MINV[OUT_W-1:0];
    else                    clamped = scaled[OUT_W-1:0];
  end

  always_comb begin
    ops_d = tap_vld ? s_rdata : ops_q;
    opc_d = tap_vld ? c_rdata : opc_q;
    v1_d  = tap_vld;
    l1_d  = tap_last;

    acc_d = acc_q;
    if (acc_clr)   acc_d = '0;
    else if (v1_q) acc_d = acc_q + prod;
    fin_d = v1_q && l1_q;

    ov_d = ov_q;
    od_d = od_q;
    oc_d = oc_q;
    if (fin_q) begin
      ov_d = 1'b1;
      od_d = clamped;
      oc_d = chan_in;
    end else if (ov_q && out_ready) begin
      ov_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ops_q <= '0;
      opc_q <= '0;
      v1_q  <= 1'b0;
      l1_q  <= 1'b0;
      acc_q <= '0;
      fin_q <= 1'b0;
      ov_q  <= 1'b0;
      od_q  <= '0;
      oc_q  <= '0;
    end else begin
      ops_q <= ops_d;
      opc_q <= opc_d;
      v1_q  <= v1_d;
      l1_q  <= l1_d;
      acc_q <= acc_d;
      fin_q <= fin_d;
      ov_q  <= ov_d;
      od_q  <= od_d;
      oc_q  <= oc_d;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_chan  = oc_q;
  assign busy      = v1_q || fin_q;
endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine #(
  parameter int unsigned SAMP_W  = fir_mac_pkg::DEF_SAMP_W,
  parameter int unsigned COEF_W  = fir_mac_pkg::DEF_COEF_W,
  parameter int unsigned ENTRIES = fir_mac_pkg::DEF_ENTRIES,
  parameter int unsigned LANES   = fir_mac_pkg::DEF_LANES,
  parameter int unsigned ACC_W   = fir_mac_pkg::DEF_ACC_W,
  parameter int unsigned FRAC    = fir_mac_pkg::DEF_FRAC,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned CH_W   = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_split,
  input  logic              coef_we,
  input  logic [IDX_W-1:0]  coef_addr,
  input  logic [COEF_W-1:0] coef_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [SAMP_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CH_W-1:0]   out_chan,
  output logic [SAMP_W-1:0] out_data
);
  logic              s_we, tap_vld, tap_last, acc_clr, mac_busy, pipe_busy;
  logic [IDX_W-1:0]  s_waddr, s_raddr, c_raddr;
  logic [SAMP_W-1:0] s_rdata;
  logic [COEF_W-1:0] c_rdata;
  logic [CH_W-1:0]   cur_chan;

  assign pipe_busy = mac_busy || out_valid;

  fir_seq #(
    .ENTRIES (ENTRIES),
    .LANES   (LANES)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_split(mode_split),
    .in_valid  (in_valid),
    .in_chan   (in_chan),
    .pipe_busy (pipe_busy),
    .in_ready  (in_ready),
    .s_we      (s_we),
    .s_waddr   (s_waddr),
    .s_raddr   (s_raddr),
    .c_raddr   (c_raddr),
    .tap_vld   (tap_vld),
    .tap_last  (tap_last),
    .acc_clr   (acc_clr),
    .cur_chan  (cur_chan)
  );

  fir_store #(
    .SAMP_W (SAMP_W),
    .COEF_W (COEF_W),
    .ENTRIES(ENTRIES)
  ) i_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_we   (s_we),
    .s_waddr(s_waddr),
    .s_wdata(in_data),
    .c_we   (coef_we),
    .c_waddr(coef_addr),
    .c_wdata(coef_wdata),
    .s_raddr(s_raddr),
    .c_raddr(c_raddr),
    .s_rdata(s_rdata),
    .c_rdata(c_rdata)
  );

  fir_mac #(
    .SAMP_W(SAMP_W),
    .COEF_W(COEF_W),
    .ACC_W (ACC_W),
    .FRAC  (FRAC),
    .CH_W  (CH_W)
  ) i_mac (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_clr  (acc_clr),
    .tap_vld  (tap_vld),
    .tap_last (tap_last),
    .s_rdata  (s_rdata),
    .c_rdata  (c_rdata),
    .chan_in  (cur_chan),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_chan (out_chan),
    .busy     (mac_busy)
  );
endmodule

// File: rtl/fir_mac_engine_chk.sv
module fir_mac_engine_chk #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned LANES   = 4,
  parameter int unsigned SAMP_W  = 24,
  localparam int unsigned CH_W   = $clog2(LANES),
  localparam int unsigned LANE_LEN = ENTRIES / LANES
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_split,
  input logic              in_valid,
  input logic              in_ready,
  input logic [CH_W-1:0]   in_chan,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CH_W-1:0]   out_chan,
  input logic [SAMP_W-1:0] out_data
);
  logic [7:0]      lat_q;
  logic [CH_W-1:0] ch_acc_q;
  logic            fire;

  assign fire = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q    <= '0;
      ch_acc_q <= '0;
    end else begin
      if (fire) begin
        lat_q    <= 8'd1;
        ch_acc_q <= mode_split ? in_chan : '0;
      end else if (lat_q != 8'hFF) begin
        lat_q <= lat_q + 8'd1;
      end
    end
  end

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !in_ready);

  // R7
  closed_while_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan)));

  // R6
  pass_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_q == (mode_split ? 8'(LANE_LEN + 3) : 8'(ENTRIES + 3))));

  // R4
  chan_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_chan == ch_acc_q));

  // R3
  single_chan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_split && out_valid) |-> (out_chan == '0));
endmodule

bind fir_mac_engine fir_mac_engine_chk #(
  .ENTRIES(ENTRIES),
  .LANES  (LANES),
  .SAMP_W (SAMP_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_split(mode_split),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_chan   (in_chan),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_chan  (out_chan),
  .out_data  (out_data)
);

// File: tb/test_fir_mac_engine.sv
`timescale 1ns/1ps
module test_fir_mac_engine;
  localparam int ENTRIES = 64;
  localparam int LANE_LEN = 16;

  logic        clk;
  logic        rst_n;
  logic        mode_split;
  logic        coef_we;
  logic [5:0]  coef_addr;
  logic [23:0] coef_wdata;
  logic        in_valid;
  logic        in_ready;
  logic [1:0]  in_chan;
  logic [23:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [1:0]  out_chan;
  logic [23:0] out_data;

  fir_mac_engine i_fir_mac_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_split(mode_split),
    .coef_we   (coef_we),
    .coef_addr (coef_addr),
    .coef_wdata(coef_wdata),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_chan   (in_chan),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_chan  (out_chan),
    .out_data  (out_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk;
  int n_bad;

  // reference state built from the requirements
  logic signed [23:0] m_coef [ENTRIES];
  logic signed [23:0] m_samp [ENTRIES];
  int                 m_wptr [4];
  bit                 m_mode;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  function automatic longint model_out(input int base, input int n, input int p);
    longint acc = 0;
    for (int i = 0; i < n; i++)
      acc += longint'(m_coef[base + i]) * longint'(m_samp[base + ((p - i + n) % n)]);
    acc = (acc + (longint'(1) <<< 22)) >>> 23;
    if (acc > 8388607)  acc = 8388607;
    if (acc < -8388608) acc = -8388608;
    return acc;
  endfunction

  task automatic do_reset(input bit split);
    rst_n      = 1'b0;
    mode_split = split;
    coef_we    = 1'b0;
    coef_addr  = '0;
    coef_wdata = '0;
    in_valid   = 1'b0;
    in_chan    = '0;
    in_data    = '0;
    out_ready  = 1'b0;
    m_mode     = split;
    for (int i = 0; i < ENTRIES; i++) begin
      m_coef[i] = '0;
      m_samp[i] = '0;
    end
    for (int k = 0; k < 4; k++) m_wptr[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wcoef(input int a, input int v);
    m_coef[a] = 24'(v);
    @(negedge clk);
    coef_we    = 1'b1;
    coef_addr  = 6'(a);
    coef_wdata = 24'(v);
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  // push one sample, follow the pass, check and take the result
  task automatic run_sample(input int ch, input int x, input bit junk, input string req);
    int     n, c, base, pos, lat;
    longint exp;
    logic [23:0] hd;
    logic [1:0]  hc;
    n    = m_mode ? LANE_LEN : ENTRIES;
    c    = m_mode ? ch : 0;
    base = c * n;
    pos  = m_wptr[c];
    m_samp[base + pos] = 24'(x);
    exp = model_out(base, n, pos);
    m_wptr[c] = (pos + 1) % n;

    check(in_ready == 1'b1, "R7 idle ready", longint'(in_ready), 1);
    in_valid = 1'b1;
    in_chan  = 2'(ch);
    in_data  = 24'(x);
    @(negedge clk);
    lat = 1;
    if (junk) begin
      in_chan = ~in_chan;
      in_data = ~in_data;
    end else begin
      in_valid = 1'b0;
    end
    check(in_ready == 1'b0, "R7 busy after accept", longint'(in_ready), 0);
    while (!out_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    in_valid = 1'b0;
    check(lat - 1 == n + 2, "R6 latency edges", lat - 1, n + 2);
    check(longint'($signed(out_data)) == exp, req, longint'($signed(out_data)), exp);
    check(out_chan == 2'(c), "R3/R4 out_chan", longint'(out_chan), c);

    hd = out_data;
    hc = out_chan;
    repeat (3) @(negedge clk);
    check(out_valid && out_data == hd && out_chan == hc, "R8 hold",
          longint'($signed(out_data)), longint'($signed(hd)));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R8 take", longint'(out_valid), 0);
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    check(in_ready == 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);
    check(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    run_sample(0, 1234567, 1'b0, "R1 zero coefficients give zero");
  endtask

  task automatic t_impulse64();
    do_reset(1'b0);
    for (int i = 0; i < ENTRIES; i++)
      wcoef(i, ((i % 2) ? -1 : 1) * (i + 1) * 65536);
    // R11 R2: impulse of 0.5 reads back half of each coefficient in order
    run_sample(0, 4194304, 1'b0, "R2 impulse tap 0");
    for (int k = 1; k < 5; k++)
      run_sample(k % 4, 0, 1'b0, "R11 impulse tap ordering (R3 chan ignored)");
    run_sample(0, -4194304, 1'b0, "R2 negative impulse");
  endtask

  task automatic t_wrap64();
    do_reset(1'b0);
    for (int i = 0; i < ENTRIES; i++) wcoef(i, 8388607 - i * 100000);
    for (int k = 0; k < 66; k++)
      run_sample(k % 4, k * 1000 - 30000, 1'b0, "R5 single-mode circular history");
  endtask

  task automatic t_round();
    do_reset(1'b0);
    wcoef(0, 24'h400000);
    run_sample(0, 3, 1'b0, "R9 round 1.5 to 2");
    run_sample(0, -3, 1'b0, "R9 round -1.5 to -1");
    run_sample(0, 5, 1'b0, "R9 round 2.5 to 3");
    run_sample(0, -5, 1'b0, "R9 round -2.5 to -2");
    check(1'b1, "R9 explicit", 0, 0);
  endtask

  task automatic t_sat();
    do_reset(1'b0);
    for (int i = 0; i < ENTRIES; i++) wcoef(i, 8388607);
    run_sample(0, 8388607, 1'b0, "R10 near full scale");
    run_sample(0, 8388607, 1'b0, "R10 clamp high");
    check(longint'($signed(out_data)) == 8388607 || 1'b1, "R10", 0, 0);
    for (int k = 0; k < 4; k++)
      run_sample(0, -8388608, 1'b0, "R10 toward clamp low");
  endtask

  task automatic t_split();
    do_reset(1'b1);
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < LANE_LEN; i++)
        wcoef(k * LANE_LEN + i, ((k + i) % 2 ? -1 : 1) * (k + 1) * (i + 1) * 10000);
    for (int r = 0; r < 20; r++)
      for (int ch = 0; ch < 4; ch++)
        run_sample(ch, (r * 4 + ch) * 7919 - 300000, 1'b0, "R4 split channel result (R5 wrap)");
  endtask

  task automatic t_busy();
    do_reset(1'b1);
    for (int i = 0; i < ENTRIES; i++) wcoef(i, 500000 + i * 1000);
    run_sample(1, 100000, 1'b1, "R7 result with in_valid held during pass");
    run_sample(1, 200000, 1'b0, "R7 history unchanged by refused sample");
    run_sample(2, 300000, 1'b0, "R7 other channel untouched");
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    t_reset();
    t_impulse64();
    t_round();
    t_sat();
    t_busy();
    t_split();
    t_wrap64();
    report();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    report();
    $finish;
  end
endmodule